// File: doc/BRIEF.md
# Pad function multiplexer with GPIO fallback

This block owns a row of chip pads. Pads are grouped into banks. For every pad it drives an output enable, an output level and a pull-up or pull-down request, and it samples the pad level back in. Each pad is claimed by a peripheral function group when that group's single enable bit is set. One group can span several pads, and several groups can overlap on one pad. When no enabled group covers a pad, the pad is driven by its own GPIO bits.

Software reaches the configuration through a small 32-bit word bus. Four address windows hold group enables, bias enables, bias directions and GPIO controls. Inside a window, each bank occupies a contiguous run of bits that starts at a bit offset set by a parameter, and two banks may share one word. Bank boundaries, field positions, group coverage and enable-bit locations are all parameters. The defaults listed below describe a 16-pad, two-bank, four-group build.

Top module: `pinmux_gpio`

## Requirements
- R1: While reset is asserted and after it is released, every group enable, bias enable, bias direction and output level bit is 0 and every direction bit is 1. All pads therefore have pad_oe_o=0, pad_pu_o=0 and pad_pd_o=0. The direction word at 0x30 reads 0x0003F3FF.
- R2: The word index is the byte address divided by 4, and address bits [1:0] are ignored. The windows are: group enables at 0x00-0x0F, bias enables at 0x10-0x1F, bias directions at 0x20-0x2F, GPIO at 0x30-0x3F. A read strobe loads bus_rdata_o at the next clock edge, and bus_rdata_o holds its value in cycles without a read strobe.
- R3: A pad at position p of a bank maps to bit (bank start bit + p - first pad of the bank). Bank 0 holds pads 0-9 and bank 1 holds pads 10-15. Default layout: bias enable at word 0x18, bits 0-9 for bank 0 and bits 16-21 for bank 1. Bias direction: bank 0 at 0x20 bits 0-9, bank 1 at 0x24 bits 4-9. Direction at 0x30, output level at 0x34 and input level at 0x38, each using bits 0-9 for bank 0 and bits 12-17 for bank 1. Bits outside these fields read 0, and writes to them are dropped.
- R4: A bias enable of 0 gives no pull. A bias enable of 1 gives a pull-up when the bias direction bit is 1 and a pull-down when it is 0. This is reported on pad_pu_o and pad_pd_o.
- R5: For a pad under GPIO control, a direction bit of 1 gives pad_oe_o=0. A direction bit of 0 gives pad_oe_o=1, with pad_do_o equal to the output level bit.
- R6: Default group enable bits: group 0 at 0x00 bit 0 covers pads 0-3; group 1 at 0x00 bit 7 covers pads 2-5; group 2 at 0x04 bit 3 covers pads 8-11; group 3 at 0x04 bit 31 covers pads 11, 14 and 15. A pad covered by an enabled group takes pad_oe_o and pad_do_o from that group's func_oe_i and func_do_i bits.
- R7: When every group covering a pad is disabled, the pad returns to GPIO control.
- R8: When more than one enabled group covers a pad, the group with the lowest number drives it.
- R9: Each pad input passes through two flops before it appears in the input level word. A change on pad_in_i shows up in a read issued two cycles after the change. Writes to the input level word are ignored.
- R10: Writes to words at byte address 0x40 and above change no state, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| func_oe_i | input | NGROUPS x NPADS | Per-group, per-pad output enable from peripherals |
| func_do_i | input | NGROUPS x NPADS | Per-group, per-pad output level from peripherals |
| pad_in_i | input | NPADS | Asynchronous pad levels |
| pad_oe_o | output | NPADS | Pad output driver enable |
| pad_do_o | output | NPADS | Pad output level |
| pad_pu_o | output | NPADS | Pull-up request |
| pad_pd_o | output | NPADS | Pull-down request |

## Verification
The properties assume that every group enable bit and every bank field lies inside the first four words of its window. That assumption lets any address at or above the mapped span be treated as dead. They also assume the read strobe and the address are stable around the clock edge, while pad_in_i may change in any cycle. The stimulus changes bus signals and pad levels only on the falling clock edge and issues at most one access per cycle. It uses both addresses inside the mapped span, including unused words and junk bits, and clearly unmapped ones. This keeps every access within what the properties assume.

// File: rtl/pinmux_gpio.sv
module pinmux_gpio #(
  parameter int NPADS       = 16,
  parameter int NBANKS      = 2,
  parameter int NGROUPS     = 4,
  parameter int ADDR_W      = 8,
  parameter int RANGE_WORDS = 4,
  parameter int BANK_FIRST [NBANKS] = '{0, 10},
  parameter int BANK_LAST  [NBANKS] = '{9, 15},
  parameter int PEN_REG    [NBANKS] = '{2, 2},
  parameter int PEN_BIT    [NBANKS] = '{0, 16},
  parameter int PUL_REG    [NBANKS] = '{0, 1},
  parameter int PUL_BIT    [NBANKS] = '{0, 4},
  parameter int DIR_REG    [NBANKS] = '{0, 0},
  parameter int OUT_REG    [NBANKS] = '{1, 1},
  parameter int IN_REG     [NBANKS] = '{2, 2},
  parameter int GPIO_BIT   [NBANKS] = '{0, 12},
  parameter logic [NPADS-1:0] GRP_PADS [NGROUPS] = '{16'h000F, 16'h003C, 16'h0F00, 16'hC800},
  parameter int GRP_REG    [NGROUPS] = '{0, 0, 1, 1},
  parameter int GRP_BIT    [NGROUPS] = '{0, 7, 3, 31}
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic                            bus_wr_i,
  input  logic [31:0]                     bus_wdata_i,
  input  logic                            bus_rd_i,
  output logic [31:0]                     bus_rdata_o,
  input  logic [NGROUPS-1:0][NPADS-1:0]   func_oe_i,
  input  logic [NGROUPS-1:0][NPADS-1:0]   func_do_i,
  input  logic [NPADS-1:0]                pad_in_i,
  output logic [NPADS-1:0]                pad_oe_o,
  output logic [NPADS-1:0]                pad_do_o,
  output logic [NPADS-1:0]                pad_pu_o,
  output logic [NPADS-1:0]                pad_pd_o
);
  localparam int WW = ADDR_W - 2;
  localparam int K_PEN = 0, K_PUL = 1, K_DIR = 2, K_OUT = 3, K_IN = 4;

  function automatic int bank_of(int p);
    int k;
    k = 0;
    for (int b = 0; b < NBANKS; b++)
      if (p >= BANK_FIRST[b] && p <= BANK_LAST[b]) k = b;
    return k;
  endfunction

  function automatic logic [WW-1:0] fword(int kind, int p);
    int k, w;
    k = bank_of(p);
    case (kind)
      K_PEN:   w = RANGE_WORDS + PEN_REG[k];
      K_PUL:   w = 2*RANGE_WORDS + PUL_REG[k];
      K_DIR:   w = 3*RANGE_WORDS + DIR_REG[k];
      K_OUT:   w = 3*RANGE_WORDS + OUT_REG[k];
      default: w = 3*RANGE_WORDS + IN_REG[k];
    endcase
    return WW'(w);
  endfunction

  function automatic logic [4:0] fbit(int kind, int p);
    int k, b;
    k = bank_of(p);
    case (kind)
      K_PEN:   b = PEN_BIT[k];
      K_PUL:   b = PUL_BIT[k];
      default: b = GPIO_BIT[k];
    endcase
    return 5'(b + p - BANK_FIRST[k]);
  endfunction

  logic [WW-1:0]      word;
  logic               unused_addr_lsb;
  logic [NGROUPS-1:0] grp_en;
  logic [NPADS-1:0]   pen_q, pul_q, dir_q, out_q, sync_q, in_q;
  logic [NPADS-1:0]   owned, sel_oe, sel_do;
  logic [31:0]        rd_val, rdata_q;

  assign word            = bus_addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_en  <= '0;
      pen_q   <= '0;
      pul_q   <= '0;
      dir_q   <= '1;
      out_q   <= '0;
      sync_q  <= '0;
      in_q    <= '0;
      rdata_q <= '0;
    end else begin
      sync_q <= pad_in_i;
      in_q   <= sync_q;
      if (bus_wr_i) begin
        for (int g = 0; g < NGROUPS; g++)
          if (word == WW'(GRP_REG[g])) grp_en[g] <= bus_wdata_i[5'(GRP_BIT[g])];
        for (int p = 0; p < NPADS; p++) begin
          if (word == fword(K_PEN, p)) pen_q[p] <= bus_wdata_i[fbit(K_PEN, p)];
          if (word == fword(K_PUL, p)) pul_q[p] <= bus_wdata_i[fbit(K_PUL, p)];
          if (word == fword(K_DIR, p)) dir_q[p] <= bus_wdata_i[fbit(K_DIR, p)];
          if (word == fword(K_OUT, p)) out_q[p] <= bus_wdata_i[fbit(K_OUT, p)];
        end
      end
      if (bus_rd_i) rdata_q <= rd_val;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NGROUPS; g++)
      if (word == WW'(GRP_REG[g])) rd_val[5'(GRP_BIT[g])] = grp_en[g];
    for (int p = 0; p < NPADS; p++) begin
      if (word == fword(K_PEN, p)) rd_val[fbit(K_PEN, p)] = pen_q[p];
      if (word == fword(K_PUL, p)) rd_val[fbit(K_PUL, p)] = pul_q[p];
      if (word == fword(K_DIR, p)) rd_val[fbit(K_DIR, p)] = dir_q[p];
      if (word == fword(K_OUT, p)) rd_val[fbit(K_OUT, p)] = out_q[p];
      if (word == fword(K_IN, p))  rd_val[fbit(K_IN, p)]  = in_q[p];
    end
  end

  always_comb begin
    owned  = '0;
    sel_oe = '0;
    sel_do = '0;
    for (int p = 0; p < NPADS; p++)
      for (int g = NGROUPS-1; g >= 0; g--)
        if (grp_en[g] && GRP_PADS[g][p]) begin
          owned[p]  = 1'b1;
          sel_oe[p] = func_oe_i[g][p];
          sel_do[p] = func_do_i[g][p];
        end
  end

  assign bus_rdata_o = rdata_q;
  assign pad_oe_o    = (owned & sel_oe) | (~owned & ~dir_q);
  assign pad_do_o    = (owned & sel_do) | (~owned & out_q);
  assign pad_pu_o    = pen_q & pul_q;
  assign pad_pd_o    = pen_q & ~pul_q;
endmodule

// File: rtl/pinmux_gpio_chk.sv
module pinmux_gpio_chk #(
  parameter int WW           = 6,
  parameter int NPADS        = 16,
  parameter int CFG_W        = 68,
  parameter int MAPPED_WORDS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WW-1:0]    word,
  input logic             bus_wr_i,
  input logic             bus_rd_i,
  input logic [31:0]      bus_rdata_o,
  input logic [NPADS-1:0] pad_in_i,
  input logic [NPADS-1:0] pad_oe_o,
  input logic [NPADS-1:0] owned,
  input logic [NPADS-1:0] dir_q,
  input logic [NPADS-1:0] in_q,
  input logic [CFG_W-1:0] cfg_state
);
  logic [1:0] age;
  logic       dead;

  assign dead = 32'(word) >= MAPPED_WORDS;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R10
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && dead |=> bus_rdata_o == '0);

  // R10
  unmapped_wr_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && dead |=> $stable(cfg_state));

  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));

  // R7
  gpio_input_undriven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~owned & dir_q & pad_oe_o) == '0);

  // R9
  sync_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age >= 2'd2 |-> in_q == $past(pad_in_i, 2));
endmodule

bind pinmux_gpio pinmux_gpio_chk #(
  .WW(ADDR_W - 2), .NPADS(NPADS), .CFG_W(NGROUPS + 4*NPADS),
  .MAPPED_WORDS(4*RANGE_WORDS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word(word), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o), .pad_in_i(pad_in_i),
  .pad_oe_o(pad_oe_o), .owned(owned), .dir_q(dir_q), .in_q(in_q),
  .cfg_state({grp_en, pen_q, pul_q, dir_q, out_q})
);

// File: tb/pinmux_gpio_bench.sv
`timescale 1ns/1ps
module pinmux_gpio_bench;
  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [7:0]           addr = '0;
  logic                 wr = 1'b0, rd = 1'b0;
  logic [31:0]          wdata = '0;
  logic [31:0]          rdata;
  logic [3:0][15:0]     f_oe, f_do;
  logic [15:0]          pin = '0;
  logic [15:0]          oe, dout, pu, pd;

  typedef struct { logic [31:0] exp; string req; logic [7:0] a; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pinmux_gpio u_pinmux_gpio (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .func_oe_i(f_oe), .func_do_i(f_do), .pad_in_i(pin),
    .pad_oe_o(oe), .pad_do_o(dout), .pad_pu_o(pu), .pad_pd_o(pd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h, want %h", req, act, exp);
    end
  endtask

  task automatic wr_w(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_w(logic [7:0] a, logic [31:0] e, string req);
    item_t it;
    it.exp = e; it.req = req; it.a = a;
    exp_q.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pads(string req, logic [15:0] e_oe, logic [15:0] e_do);
    chk({req, " oe"}, 32'(oe), 32'(e_oe));
    chk({req, " do"}, 32'(dout), 32'(e_do));
  endtask

  always begin
    @(posedge clk);
    if (rd) begin
      item_t it;
      @(negedge clk);
      it = exp_q.pop_front();
      chk($sformatf("%s @%h", it.req, it.a), rdata, it.exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    f_oe = {4{16'hFFFF}};
    f_do = {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000};
    repeat (3) @(negedge clk);
    // R1 state while reset is held
    pads("R1 in reset", 16'h0000, 16'h0000);
    chk("R1 pulls in reset", 32'({pu, pd}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_w(8'h30, 32'h0003F3FF, "R1 dir reset");
    rd_w(8'h34, 32'h0, "R1 out reset");
    rd_w(8'h00, 32'h0, "R1 mux reset");

    // R5 GPIO outputs on pads 0,1,12; R3 junk bits dropped
    wr_w(8'h30, 32'h0003B3FC);
    wr_w(8'h34, 32'h80004C01);
    pads("R5 gpio drive", 16'h1003, 16'h1001);
    rd_w(8'h34, 32'h00004001, "R3 out fields only");
    rd_w(8'h31, 32'h0003B3FC, "R2 low addr bits ignored");

    // R4 bias
    wr_w(8'h18, 32'h00020028);
    wr_w(8'h20, 32'h00000088);
    wr_w(8'h24, 32'h00000020);
    chk("R4 pull-up", 32'(pu), 32'h0808);
    chk("R4 pull-down", 32'(pd), 32'h0020);
    rd_w(8'h18, 32'h00020028, "R3 shared bias enable word");
    rd_w(8'h24, 32'h00000020, "R3 bank1 bias field");

    // R6 group 1 takes pads 2-5
    wr_w(8'h00, 32'h00000080);
    pads("R6 group1", 16'h103F, 16'h103D);
    // R8 group 0 wins pads 2,3
    wr_w(8'h00, 32'h0000FF81);
    pads("R8 group0 over group1", 16'h103F, 16'h1030);
    rd_w(8'h00, 32'h00000081, "R6 enable bits only");
    // R8 group 2 wins pad 11 over group 3
    wr_w(8'h04, 32'h80000008);
    pads("R8 group2 over group3", 16'hDF3F, 16'hD030);
    rd_w(8'h04, 32'h80000008, "R6 second mux word");
    rd_w(8'h0C, 32'h0, "R2 unused mux word");
    // R7 fallback
    wr_w(8'h00, 32'h0);
    wr_w(8'h04, 32'h0);
    pads("R7 fallback to gpio", 16'h1003, 16'h1001);

    // R9 synchroniser latency
    pin = 16'hA5C3;
    rd_w(8'h38, 32'h0, "R9 first cycle old");
    rd_w(8'h38, 32'h0, "R9 second cycle old");
    rd_w(8'h38, 32'h000291C3, "R9 new level");
    wr_w(8'h38, 32'hFFFFFFFF);
    rd_w(8'h38, 32'h000291C3, "R9 input word read-only");

    // R10 unmapped
    wr_w(8'h40, 32'hFFFFFFFF);
    wr_w(8'hFC, 32'hFFFFFFFF);
    rd_w(8'h40, 32'h0, "R10 read 0x40");
    rd_w(8'hFC, 32'h0, "R10 read 0xFC");
    rd_w(8'h30, 32'h0003B3FC, "R10 dir untouched");
    pads("R10 pads untouched", 16'h1003, 16'h1001);
    chk("R10 pulls untouched", 32'({pu, pd}), 32'h08080020);

    // R1 reset again
    rst_n = 1'b0;
    #1;
    pads("R1 re-reset", 16'h0000, 16'h0000);
    chk("R1 re-reset pulls", 32'({pu, pd}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_w(8'h30, 32'h0003F3FF, "R1 dir after re-reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule